// File: doc/BRIEF.md
# Half-Bridge Complementary PWM Generator

This block drives the two switches of a half-bridge. It makes a primary PWM waveform and its logical complement. A programmable dead-band delay holds back the turn-on edge of each waveform, so that one switch is fully off before the other switch turns on. A free-running period timer advances once per clock-enable tick and restarts at the programmed period value. The primary drive is nominally active from the start of a period until the timer reaches the duty value. The complement is nominally active for the rest of the period.

The period, duty, dead-band and enable inputs are copied into shadow registers only when a period ends, so software may change them at any time without disturbing the period in progress. Turn-off edges are never delayed. If the delay is longer than the time an output would be active, that output stays low for its whole phase. Both drives are active-high. A one-cycle strobe marks the start of every period.

Top module: `hb_pwm`

## Requirements
- R1: While rst_ni is low, pwm_a_o, pwm_b_o and strobe_o are low and the period timer is cleared.
- R2: With a latched period value P, each period lasts P+1 ticks (timer values 0 to P). strobe_o is high for exactly one clock cycle, the first cycle of each period (the cycle after the tick on which the timer wrapped).
- R3: With a latched duty value D where 1 <= D <= P, the primary drive is nominally active for timer values t < D and the complement for D <= t <= P. With a dead-band count of 0, pwm_b_o is the exact inverse of pwm_a_o whenever enabled.
- R4: With dead-band count N (7 bits, 0 to 127), each output turns on N ticks after its nominal rising edge: the primary is high for N <= t < D and the complement for D+N <= t <= P. Turn-off is not delayed, so each gap lasts exactly N ticks.
- R5: If N is at least the length of an output's nominal active phase, that output stays low for that entire phase.
- R6: pwm_a_o and pwm_b_o are never high in the same cycle.
- R7: With D = 0, pwm_a_o stays low for the whole period. pwm_b_o stays high across period boundaries and is not delayed again at each boundary.
- R8: With D > P, pwm_b_o stays low for the whole period. pwm_a_o stays high across period boundaries.
- R9: Period, duty, dead-band and enable inputs take effect only at a period boundary. A change in the middle of a period leaves the rest of that period unchanged.
- R10: The timer, the dead-band counting and the outputs change only on clock edges where tick_i is high. Timing is counted in ticks, not in clock cycles.
- R11: When the latched enable is 0, both drives are low while the timer and strobe keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock-enable tick for all counting |
| en_i | input | 1 | Output enable, latched at period boundary |
| period_i | input | W | Period value P (period is P+1 ticks) |
| duty_i | input | W | Duty value D for the primary drive |
| dead_i | input | 7 | Dead-band count N in ticks |
| pwm_a_o | output | 1 | Primary drive, active high |
| pwm_b_o | output | 1 | Complementary drive, active high |
| strobe_o | output | 1 | One-cycle pulse at the start of each period |

## Verification
Every test compares each drive, tick by tick over whole periods, with a waveform worked out from P, D and N. This measures each dead-band gap and each active width directly. The patterns are: a zero delay (exact complement), a delay shorter than both phases, a delay longer than the primary phase, a delay longer than the complement phase, duty 0, and duty above the period. Together these separate a delay applied to the turn-on edge from one applied to the turn-off edge, and a correct clip to "low for the whole phase" from a wrap or a leak. A slow tick divider shows that the delay and the period are counted in ticks. A mid-period change of all settings shows whether the shadow registers load early. The disabled run shows that the timer keeps running while both drives stay low.

// File: rtl/hb_pwm_pkg.sv
package hb_pwm_pkg;
  localparam int unsigned DB_W    = 7;
  localparam int unsigned N_OUT   = 2;
  localparam int unsigned IDX_PRI = 0;
  localparam int unsigned IDX_CMP = 1;
  typedef logic [DB_W-1:0] db_t;
endpackage

// File: rtl/hb_pwm_timer.sv
module hb_pwm_timer
  import hb_pwm_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         en_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] duty_i,
  input  db_t          dead_i,
  output logic [W-1:0] tmr_o,
  output logic [W-1:0] per_o,
  output logic [W-1:0] duty_o,
  output db_t          dead_o,
  output logic         en_o,
  output logic         strobe_o
);
  logic [W-1:0] tmr_q, per_q, duty_q;
  db_t          dead_q;
  logic         en_q, strobe_q, wrap;

  assign wrap = tick_i && (tmr_q == per_q);

  // shadow registers load only on the wrap tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q    <= '0;
      per_q    <= '0;
      duty_q   <= '0;
      dead_q   <= '0;
      en_q     <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= wrap;
      if (wrap) begin
        tmr_q  <= '0;
        per_q  <= period_i;
        duty_q <= duty_i;
        dead_q <= dead_i;
        en_q   <= en_i;
      end else if (tick_i) begin
        tmr_q <= tmr_q + 1'b1;
      end
    end
  end

  assign tmr_o    = tmr_q;
  assign per_o    = per_q;
  assign duty_o   = duty_q;
  assign dead_o   = dead_q;
  assign en_o     = en_q;
  assign strobe_o = strobe_q;
endmodule

// File: rtl/hb_pwm_deadband.sv
module hb_pwm_deadband
  import hb_pwm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic nom_i,
  input  db_t  dead_i,
  output logic drv_o
);
  localparam db_t RUN_MAX = '1;

  db_t run_q;

  // ticks the nominal level has been high, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
    end else if (tick_i) begin
      if (!nom_i) begin
        run_q <= '0;
      end else if (run_q != RUN_MAX) begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  // turn-off is immediate, turn-on waits for the count
  assign drv_o = nom_i && (run_q >= dead_i);
endmodule

// File: rtl/hb_pwm.sv
module hb_pwm
  import hb_pwm_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            en_i,
  input  logic [W-1:0]    period_i,
  input  logic [W-1:0]    duty_i,
  input  logic [DB_W-1:0] dead_i,
  output logic            pwm_a_o,
  output logic            pwm_b_o,
  output logic            strobe_o
);
  logic [W-1:0]     tmr, per_q, duty_q;
  db_t              dead_q;
  logic             en_q, a_on;
  logic [N_OUT-1:0] nom, drv;

  hb_pwm_timer #(.W(W)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .en_i     (en_i),
    .period_i (period_i),
    .duty_i   (duty_i),
    .dead_i   (dead_i),
    .tmr_o    (tmr),
    .per_o    (per_q),
    .duty_o   (duty_q),
    .dead_o   (dead_q),
    .en_o     (en_q),
    .strobe_o (strobe_o)
  );

  assign a_on         = (tmr < duty_q);
  assign nom[IDX_PRI] = en_q && a_on;
  assign nom[IDX_CMP] = en_q && !a_on;

  for (genvar g = 0; g < N_OUT; g++) begin : g_db
    hb_pwm_deadband i_db (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .nom_i  (nom[g]),
      .dead_i (dead_q),
      .drv_o  (drv[g])
    );
  end

  assign pwm_a_o = drv[IDX_PRI];
  assign pwm_b_o = drv[IDX_CMP];
endmodule

// File: rtl/hb_pwm_chk.sv
module hb_pwm_chk
  import hb_pwm_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         pwm_a_i,
  input logic         pwm_b_i,
  input logic         strobe_i,
  input logic         en_q_i,
  input logic [W-1:0] tmr_i,
  input logic [W-1:0] per_i,
  input logic [W-1:0] duty_i,
  input db_t          dead_i
);
  // R6
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pwm_a_i && pwm_b_i));

  // R2
  tmr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_i <= per_i);

  // R2
  strobe_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |-> (tmr_i == '0));

  // R4
  gap_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pwm_a_i) && (dead_i != '0)) |-> !$past(pwm_b_i));

  // R4
  gap_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pwm_b_i) && (dead_i != '0)) |-> !$past(pwm_a_i));

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(tmr_i) && $stable(pwm_a_i) && $stable(pwm_b_i)));

  // R7
  duty_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q_i && (duty_i == '0)) |-> !pwm_a_i);

  // R8
  duty_over_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q_i && (duty_i > per_i)) |-> !pwm_b_i);

  // R11
  disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q_i |-> (!pwm_a_i && !pwm_b_i));
endmodule

bind hb_pwm hb_pwm_chk #(.W(W)) i_hb_pwm_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .pwm_a_i  (pwm_a_o),
  .pwm_b_i  (pwm_b_o),
  .strobe_i (strobe_o),
  .en_q_i   (en_q),
  .tmr_i    (tmr),
  .per_i    (per_q),
  .duty_i   (duty_q),
  .dead_i   (dead_q)
);

// File: tb/test_hb_pwm.sv
`timescale 1ns/1ps
module test_hb_pwm;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tick_i = 1'b0;
  logic         en_i = 1'b0;
  logic [W-1:0] period_i = '0;
  logic [W-1:0] duty_i = '0;
  logic [6:0]   dead_i = '0;
  logic         pwm_a_o, pwm_b_o, strobe_o;

  int total = 0;
  int bad = 0;
  int tdiv = 1;
  int divc = 0;
  bit tick_run = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hb_pwm #(.W(W)) i_hb_pwm (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .en_i     (en_i),
    .period_i (period_i),
    .duty_i   (duty_i),
    .dead_i   (dead_i),
    .pwm_a_o  (pwm_a_o),
    .pwm_b_o  (pwm_b_o),
    .strobe_o (strobe_o)
  );

  // tick generator: one tick every tdiv cycles
  initial begin
    forever begin
      @(negedge clk);
      if (!tick_run) begin
        tick_i = 1'b0;
      end else begin
        tick_i = (divc == tdiv - 1);
        divc   = (divc == tdiv - 1) ? 0 : divc + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_a(int t, int p, int d, int n, bit en);
    if (!en || d == 0) return 1'b0;
    if (d > p) return 1'b1;
    return (t >= n) && (t < d);
  endfunction

  function automatic bit exp_b(int t, int p, int d, int n, bit en);
    if (!en) return 1'b0;
    if (d == 0) return 1'b1;
    if (d > p) return 1'b0;
    return (t >= d + n) && (t <= p);
  endfunction

  task automatic set_cfg(int p, int d, int n, bit en);
    period_i = W'(p);
    duty_i   = W'(d);
    dead_i   = 7'(n);
    en_i     = en;
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (!strobe_o);
  endtask

  // apply settings, skip the first (transition) period, land at a strobe
  task automatic apply(int p, int d, int n, bit en);
    set_cfg(p, d, n, en);
    wait_strobe();
    wait_strobe();
  endtask

  // called at the strobe cycle; checks one whole period tick by tick.
  // at cycle chg_k the inputs are changed to the *_n values.
  task automatic check_period(input string req, int p, int d, int n, bit en,
                              int chg_k, int pn, int dn, int nn);
    int len = (p + 1) * tdiv;
    int err_a = 0, err_b = 0, ovl = 0, xstb = 0;
    int fa = -1, fb = -1;
    for (int k = 0; k < len; k++) begin
      int t = k / tdiv;
      if (k == chg_k) set_cfg(pn, dn, nn, en);
      if (pwm_a_o !== exp_a(t, p, d, n, en)) begin
        err_a++;
        if (fa < 0) fa = k;
      end
      if (pwm_b_o !== exp_b(t, p, d, n, en)) begin
        err_b++;
        if (fb < 0) fb = k;
      end
      if (pwm_a_o && pwm_b_o) ovl++;
      if (k > 0 && strobe_o) xstb++;
      if (k != len - 1) @(negedge clk);
    end
    chk(err_a == 0, req, $sformatf("pwm_a mismatches (first cycle %0d)", fa), err_a, 0);
    chk(err_b == 0, req, $sformatf("pwm_b mismatches (first cycle %0d)", fb), err_b, 0);
    chk(ovl == 0, "R6", "cycles with both drives high", ovl, 0);
    chk(xstb == 0, "R2", "extra strobes inside period", xstb, 0);
    @(negedge clk);
    chk(strobe_o == 1'b1, "R2", "strobe after P+1 ticks", int'(strobe_o), 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(pwm_a_o == 1'b0, "R1", "pwm_a in reset", int'(pwm_a_o), 0);
    chk(pwm_b_o == 1'b0, "R1", "pwm_b in reset", int'(pwm_b_o), 0);
    chk(strobe_o == 1'b0, "R1", "strobe in reset", int'(strobe_o), 0);
    set_cfg(5, 2, 1, 1'b0);
    tick_run = 1'b1;
    @(negedge clk);
    rst_ni = 1'b1;
    wait_strobe();
    wait_strobe();
    // R11 disabled: timer and strobe keep running, drives low
    check_period("R11", 5, 2, 1, 1'b0, -1, 0, 0, 0);
  endtask

  task automatic t_complement();
    apply(9, 4, 0, 1'b1);
    check_period("R3", 9, 4, 0, 1'b1, -1, 0, 0, 0);
    check_period("R3", 9, 4, 0, 1'b1, -1, 0, 0, 0);
  endtask

  task automatic t_deadband();
    apply(15, 8, 3, 1'b1);
    check_period("R4", 15, 8, 3, 1'b1, -1, 0, 0, 0);
    check_period("R4", 15, 8, 3, 1'b1, -1, 0, 0, 0);
  endtask

  task automatic t_clip();
    apply(15, 2, 5, 1'b1);
    check_period("R5", 15, 2, 5, 1'b1, -1, 0, 0, 0);
    apply(9, 7, 4, 1'b1);
    check_period("R5", 9, 7, 4, 1'b1, -1, 0, 0, 0);
  endtask

  task automatic t_duty_zero();
    apply(7, 0, 2, 1'b1);
    check_period("R7", 7, 0, 2, 1'b1, -1, 0, 0, 0);
    check_period("R7", 7, 0, 2, 1'b1, -1, 0, 0, 0);
  endtask

  task automatic t_duty_over();
    apply(7, 12, 2, 1'b1);
    check_period("R8", 7, 12, 2, 1'b1, -1, 0, 0, 0);
    check_period("R8", 7, 12, 2, 1'b1, -1, 0, 0, 0);
  endtask

  task automatic t_midchange();
    apply(11, 5, 1, 1'b1);
    check_period("R9", 11, 5, 1, 1'b1, 6, 7, 3, 2);
    check_period("R9", 7, 3, 2, 1'b1, -1, 0, 0, 0);
  endtask

  task automatic t_slow_tick();
    tdiv = 3;
    divc = 0;
    apply(6, 3, 2, 1'b1);
    check_period("R10", 6, 3, 2, 1'b1, -1, 0, 0, 0);
    check_period("R10", 6, 3, 2, 1'b1, -1, 0, 0, 0);
    tdiv = 1;
    divc = 0;
  endtask

  initial begin
    t_reset();
    t_complement();
    t_deadband();
    t_clip();
    t_duty_zero();
    t_duty_over();
    t_midchange();
    t_slow_tick();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule